// File: doc/BRIEF.md
# Dual Complex Adder-Accumulator

This block is a two-lane signed arithmetic datapath. One lane carries the real part and one carries the imaginary part. Both lanes read the same pair of 16-bit input registers, X (loaded from `a_in`) and Y (loaded from `b_in`). Each lane sign-extends its operands to 20 bits and runs them through its own adder/subtractor. The result lands in a 20-bit accumulator register. A shared feedback select swaps a lane's X operand for that lane's own accumulator, which turns the lanes into running sums for complex filters. A shared clear empties both accumulators.

The real lane has an extra switchable deskew line on its X operand. The line delays the A-port data by eight cycles, so it can be lined up with a partner path that has that much pipeline latency. A typical radix-2 butterfly sets the real lane to X+Y and the imaginary lane to X−Y on the same operands. Both lanes produce a new result every cycle.

All pins are plain levels. The datapath has no stall path: a result is produced every cycle, and the two active-low register enables are the only way to hold data.

Top module: `cxacc_pair`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, both results and both overflow flags read zero.
- R2: Each lane's 2-bit operation select is encoded as 00 = X+Y, 01 = X (pass), 10 = X−Y, 11 = Y−X. Each lane follows its own select.
- R3: When `fb_sel` is 1, each lane uses its own accumulator in place of X. When `fb_sel` is 0, it uses the register data.
- R4: A captured `acc_clr` of 1 sets both accumulators and both overflow flags to zero at the next edge. This overrides the operation.
- R5: When `dly_sel` is 1, the real lane's X operand is the `a_in` value presented eight cycles earlier than the one the direct path would use. The imaginary lane always uses the direct path.
- R6: An overflow flag goes to 1 for exactly the cycles whose stored result is a signed 20-bit add or subtract that went out of range. The stored value wraps modulo 2^20, and pass never flags.
- R7: When `a_ce_n` is 1, the X register holds its value. When `b_ce_n` is 1, the Y register holds its value. The deskew line shifts every cycle regardless of either enable.
- R8: Data and controls are captured at edge k, and the outputs show the resulting values after edge k+1. A new result is produced on every cycle.
- R9: Inputs are two's complement and are sign-extended from 16 to 20 bits before the arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | 16 | A-port data (X operand source) |
| b_in | input | 16 | B-port data (Y operand source) |
| a_ce_n | input | 1 | Active-low load enable of the X register |
| b_ce_n | input | 1 | Active-low load enable of the Y register |
| op_re | input | 2 | Real lane operation select |
| op_im | input | 2 | Imaginary lane operation select |
| fb_sel | input | 1 | Accumulator feedback select, both lanes |
| acc_clr | input | 1 | Clear of both accumulators |
| dly_sel | input | 1 | Real lane X taken from the deskew line |
| re_o | output | 20 | Real lane accumulator |
| im_o | output | 20 | Imaginary lane accumulator |
| ovf_re_o | output | 1 | Real lane overflow flag |
| ovf_im_o | output | 1 | Imaginary lane overflow flag |

## Verification
The assertions assume that every input holds a known 0/1 value at each rising edge once reset is released. They also assume the captured operation code is always one of the four legal codes, which holds because every 2-bit value is defined. The stimulus changes inputs only on the falling edge and drives every control explicitly in every cycle, so no X state ever reaches the registers. The bench sweeps every pair of lane operations over boundary operands, and runs long feedback sums that are built to cross both signed limits.

// File: rtl/cxacc_pkg.sv
package cxacc_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_PASS = 2'b01,
    OP_XMY  = 2'b10,
    OP_YMX  = 2'b11
  } op_e;
endpackage

// File: rtl/cxacc_delay.sv
module cxacc_delay #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  // stage 0 samples the port like the X register would; DEPTH more stages add the skew
  logic [W-1:0] stg [0:DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= din;
  end

  for (genvar i = 1; i <= DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[DEPTH];
endmodule

// File: rtl/cxacc_lane.sv
module cxacc_lane
  import cxacc_pkg::*;
#(
  parameter int IW = 16,
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    op_i,
  input  logic          fb_sel,
  input  logic          clr,
  input  logic [IW-1:0] x_in,
  input  logic [IW-1:0] y_in,
  output logic [AW-1:0] acc_o,
  output logic          ovf_o
);
  localparam int EXT = AW - IW;
  localparam int MSB = AW - 1;

  op_e          op;
  logic [AW-1:0] acc_q, opx, opy, res_c;
  logic          ovf_q, ovf_c;

  assign op  = op_e'(op_i);
  assign opy = {{EXT{y_in[IW-1]}}, y_in};
  assign opx = fb_sel ? acc_q : {{EXT{x_in[IW-1]}}, x_in};

  always_comb begin
    res_c = opx;
    ovf_c = 1'b0;
    case (op)
      OP_ADD: begin
        res_c = opx + opy;
        ovf_c = (opx[MSB] == opy[MSB]) && (res_c[MSB] != opx[MSB]);
      end
      OP_PASS: begin
        res_c = opx;
        ovf_c = 1'b0;
      end
      OP_XMY: begin
        res_c = opx - opy;
        ovf_c = (opx[MSB] != opy[MSB]) && (res_c[MSB] != opx[MSB]);
      end
      OP_YMX: begin
        res_c = opy - opx;
        ovf_c = (opx[MSB] != opy[MSB]) && (res_c[MSB] != opy[MSB]);
      end
      default: begin
        res_c = opx;
        ovf_c = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      acc_q <= res_c;
      ovf_q <= ovf_c;
    end
  end

  assign acc_o = acc_q;
  assign ovf_o = ovf_q;

  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0 && !ovf_q));

  p_pass_no_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && op == OP_PASS) |=> !ovf_q);

  p_fb_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && fb_sel && op == OP_PASS) |=> $stable(acc_q));

  p_same_sign_add_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !fb_sel && op == OP_ADD) |=> !ovf_q);
endmodule

// File: rtl/cxacc_pair.sv
module cxacc_pair
  import cxacc_pkg::*;
#(
  parameter int IW    = 16,
  parameter int AW    = 20,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] a_in,
  input  logic [IW-1:0] b_in,
  input  logic          a_ce_n,
  input  logic          b_ce_n,
  input  logic [1:0]    op_re,
  input  logic [1:0]    op_im,
  input  logic          fb_sel,
  input  logic          acc_clr,
  input  logic          dly_sel,
  output logic [AW-1:0] re_o,
  output logic [AW-1:0] im_o,
  output logic          ovf_re_o,
  output logic          ovf_im_o
);
  logic [IW-1:0] x_q, y_q, tap, x_re;
  logic [1:0]    op_re_q, op_im_q;
  logic          fb_q, clr_q, dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q     <= '0;
      y_q     <= '0;
      op_re_q <= OP_ADD;
      op_im_q <= OP_ADD;
      fb_q    <= 1'b0;
      clr_q   <= 1'b0;
      dly_q   <= 1'b0;
    end else begin
      if (!a_ce_n) x_q <= a_in;
      if (!b_ce_n) y_q <= b_in;
      op_re_q <= op_re;
      op_im_q <= op_im;
      fb_q    <= fb_sel;
      clr_q   <= acc_clr;
      dly_q   <= dly_sel;
    end
  end

  cxacc_delay #(.W(IW), .DEPTH(DEPTH)) u_deskew (
    .clk (clk), .rst_n (rst_n), .din (a_in), .dout (tap)
  );

  assign x_re = dly_q ? tap : x_q;

  cxacc_lane #(.IW(IW), .AW(AW)) u_re (
    .clk (clk), .rst_n (rst_n), .op_i (op_re_q), .fb_sel (fb_q), .clr (clr_q),
    .x_in (x_re), .y_in (y_q), .acc_o (re_o), .ovf_o (ovf_re_o)
  );

  cxacc_lane #(.IW(IW), .AW(AW)) u_im (
    .clk (clk), .rst_n (rst_n), .op_i (op_im_q), .fb_sel (fb_q), .clr (clr_q),
    .x_in (x_q), .y_in (y_q), .acc_o (im_o), .ovf_o (ovf_im_o)
  );

  p_x_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    a_ce_n |=> $stable(x_q));

  p_y_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    b_ce_n |=> $stable(y_q));

  p_clear_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> ##1 (re_o == '0 && im_o == '0 && !ovf_re_o && !ovf_im_o));
endmodule

// File: tb/test_cxacc_pair.sv
`timescale 1ns/1ps
module test_cxacc_pair;
  localparam int IW = 16, AW = 20, DEPTH = 8;
  localparam int LIM = 1 << (AW - 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic [IW-1:0] a_in, b_in;
  logic          a_ce_n, b_ce_n, fb_sel, acc_clr, dly_sel;
  logic [1:0]    op_re, op_im;
  logic [AW-1:0] re_o, im_o;
  logic          ovf_re_o, ovf_im_o;

  cxacc_pair #(.IW(IW), .AW(AW), .DEPTH(DEPTH)) i_cxacc_pair (
    .clk (clk), .rst_n (rst_n), .a_in (a_in), .b_in (b_in),
    .a_ce_n (a_ce_n), .b_ce_n (b_ce_n), .op_re (op_re), .op_im (op_im),
    .fb_sel (fb_sel), .acc_clr (acc_clr), .dly_sel (dly_sel),
    .re_o (re_o), .im_o (im_o), .ovf_re_o (ovf_re_o), .ovf_im_o (ovf_im_o)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // arithmetic model state
  int m_x, m_y, m_opr, m_opi, m_fb, m_clr, m_dsel;
  int m_re, m_im, m_ovr, m_ovi;
  int m_dly [0:DEPTH];

  function automatic int sx16(logic [IW-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int wrap(int s);
    int w = s & ((1 << AW) - 1);
    if (w >= LIM) w -= (1 << AW);
    return w;
  endfunction

  function automatic int raw(int op, int x, int y);
    case (op)
      0: return x + y;
      1: return x;
      2: return x - y;
      default: return y - x;
    endcase
  endfunction

  task automatic model_reset();
    m_x = 0; m_y = 0; m_opr = 0; m_opi = 0; m_fb = 0; m_clr = 0; m_dsel = 0;
    m_re = 0; m_im = 0; m_ovr = 0; m_ovi = 0;
    for (int i = 0; i <= DEPTH; i++) m_dly[i] = 0;
  endtask

  task automatic model_edge();
    int xr, xi, sr, si;
    xr = m_dsel ? m_dly[DEPTH] : m_x;
    if (m_fb) xr = m_re;
    xi = m_fb ? m_im : m_x;
    sr = raw(m_opr, xr, m_y);
    si = raw(m_opi, xi, m_y);
    if (m_clr) begin
      m_re = 0; m_im = 0; m_ovr = 0; m_ovi = 0;
    end else begin
      m_ovr = (sr >= LIM || sr < -LIM); m_re = wrap(sr);
      m_ovi = (si >= LIM || si < -LIM); m_im = wrap(si);
    end
    for (int i = DEPTH; i > 0; i--) m_dly[i] = m_dly[i-1];
    m_dly[0] = sx16(a_in);
    if (!a_ce_n) m_x = sx16(a_in);
    if (!b_ce_n) m_y = sx16(b_in);
    m_opr = op_re; m_opi = op_im; m_fb = fb_sel; m_clr = acc_clr; m_dsel = dly_sel;
  endtask

  task automatic compare(string tag);
    int gr, gi;
    gr = int'($signed(re_o));
    gi = int'($signed(im_o));
    n_tests++;
    if (gr != m_re || gi != m_im || ovf_re_o != m_ovr[0] || ovf_im_o != m_ovi[0]) begin
      n_fail++;
      $display("FAIL %s: got re=%0d im=%0d ovr=%0b ovi=%0b, expected re=%0d im=%0d ovr=%0d ovi=%0d",
               tag, gr, gi, ovf_re_o, ovf_im_o, m_re, m_im, m_ovr, m_ovi);
    end
  endtask

  task automatic step(input logic [IW-1:0] a, input logic [IW-1:0] b,
                      input logic cea_n, input logic ceb_n,
                      input logic [1:0] opr, input logic [1:0] opi,
                      input logic fb, input logic clr, input logic ds,
                      input string tag);
    @(negedge clk);
    a_in = a; b_in = b; a_ce_n = cea_n; b_ce_n = ceb_n;
    op_re = opr; op_im = opi; fb_sel = fb; acc_clr = clr; dly_sel = ds;
    @(posedge clk);
    #1;
    model_edge();
    compare(tag);
  endtask

  logic [IW-1:0] pat [0:5];

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got no finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    pat[0] = 16'h7FFF; pat[1] = 16'h8000; pat[2] = 16'h0001;
    pat[3] = 16'hFFFF; pat[4] = 16'h1234; pat[5] = 16'h0000;
    rst_n = 1'b0; a_in = '0; b_in = '0; a_ce_n = 1'b0; b_ce_n = 1'b0;
    op_re = 2'b00; op_im = 2'b00; fb_sel = 1'b0; acc_clr = 1'b0; dly_sel = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 compare("R1 reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    model_edge();
    compare("R1 first cycle");

    // R2 / R9 / R8: every operation pair over boundary operands, result every cycle
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          step(pat[i], pat[j], 0, 0, o[3:2], o[1:0], 0, 0, 0, "R2 R9 op sweep");

    // R8: controls change every cycle
    for (int k = 0; k < 40; k++)
      step(16'(k * 977), 16'(k * 31 - 600), 0, 0, 2'(k), 2'(k + 1), 0, 0, 0, "R8 latency");

    // R4: clear, then R3 feedback accumulation
    step(16'h0100, 16'h0010, 0, 0, 0, 0, 0, 1, 0, "R4 clear");
    step(16'h0100, 16'h0010, 0, 0, 0, 0, 0, 0, 0, "R4 clear");
    for (int k = 0; k < 20; k++)
      step(16'h0005, 16'(1000 + k), 0, 0, 2'b00, 2'b11, 1, 0, 0, "R3 feedback");
    for (int k = 0; k < 6; k++)
      step(16'h0005, 16'h0007, 0, 0, 2'b01, 2'b01, 1, 0, 0, "R3 hold");

    // R6: push both lanes past the signed limits and watch the wrap
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R4 clear");
    for (int k = 0; k < 40; k++)
      step(16'h7FFF, 16'h7FFF, 0, 0, 2'b00, 2'b10, 1, 0, 0, "R6 overflow");
    step(0, 16'h8000, 0, 0, 0, 0, 0, 1, 0, "R4 clear");
    for (int k = 0; k < 40; k++)
      step(16'h8000, 16'h8000, 0, 0, 2'b11, 2'b00, 1, 0, 0, "R6 overflow neg");
    step(0, 0, 0, 0, 2'b01, 2'b01, 0, 1, 0, "R4 clear");

    // R5: deskew line on the real lane only
    for (int k = 0; k < 40; k++)
      step(16'(k * 321 + 7), 16'h0003, 0, 0, 2'b01, 2'b01, 0, 0, 1, "R5 deskew");
    for (int k = 0; k < 12; k++)
      step(16'(k * 55 - 100), 16'h0002, 1, 0, 2'b00, 2'b10, 0, 0, (k % 3 != 0), "R5 R7 deskew ce");

    // R7: enables hold the registers
    for (int k = 0; k < 30; k++)
      step(16'(k * 4099), 16'(k * 2111 + 5), k[0], k[1], 2'b00, 2'b11, 0, 0, 0, "R7 enables");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule